// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Decoder

This block is a cycle-accurate behavioural model of the device-side control logic of a 64K x 16 dynamic RAM. A fast clock samples the row strobe, two byte column strobes (lower and upper), the write enable, the output enable and an 8-bit multiplexed address. From these pins the block works out which kind of memory cycle is in progress and latches the row and column addresses. It also produces per-byte output-enable and write-strobe signals for a small behavioural storage array, and keeps an internal refresh row counter that advances on every strobe-first refresh.

The two byte strobes merge into one internal column strobe. It becomes active when the first of the two falls and inactive only when the last of them rises. Each strobe still gates the tristate and the write of its own byte. A per-row age counter raises a flag when any tracked row goes a parameterised number of clocks without a refresh. The array covers only the low address bits of the row and the column, so that it stays small in simulation.

All inputs are active low and are sampled on the rising clock edge. The data outputs and output enables follow combinationally from the current pins and the registered cycle state.

Top module: `dualcas_dram_core`

## Requirements
- R1: The internal column strobe becomes active on the first byte strobe to fall and stays active until both byte strobes are high. Only that first fall latches a column address, so a second strobe falling later in the same access uses the column already held.
- R2: A row-strobe fall while both byte strobes are high latches the address as the row, reports cycle code 1 (row only) and refreshes that row. The code stays 1 while no byte strobe falls, and no data is driven.
- R3: A row-strobe fall while a byte strobe was already low, with no read data held, reports code 6. It refreshes the row given by the internal counter, ignores the address and then advances the counter by one, and drives no data.
- R4: With the row strobe low, a byte strobe low, write enable high and output enable low, that byte drives the stored word's byte. dq_oe bit 0 belongs to the lower byte (dq[7:0]) and bit 1 to the upper byte. The first column strobe fall with write enable high reports code 2.
- R5: If write enable is low at the first column strobe fall, the cycle is an early write (code 3). Each byte whose strobe is low is written with the input data at that fall, and no output is driven during the cycle.
- R6: If write enable falls after the column strobe with output enable high and no data driven, the cycle is a late write (code 4). The input data is captured at the write-enable fall.
- R7: If a byte drove read data at the current column and write enable then falls, the cycle is a read-modify-write (code 5) and the new data is stored.
- R8: If a byte strobe stays low while the row strobe rises and falls again after data was driven, the cycle is a hidden refresh (code 7). The counter row is refreshed, the counter advances, the latched row is kept and the previous read data stays on the outputs.
- R9: When the row strobe and both byte strobes are high, no byte drives the data outputs.
- R10: Each row index (the low ROW_SEL bits of a refreshed row) has an age that counts clocks since its last refresh. row_stale is high while any age has reached REF_WINDOW.
- R11: After reset the cycle code is 0, the counter is 0, row_stale is low, no byte drives, and the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Lower-byte column strobe, active low |
| cas_hi_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 16 | Write data |
| dq_out | output | 16 | Read data, zero in bytes not driven |
| dq_oe | output | 2 | Per-byte drive enable {upper, lower} |
| cyc_kind | output | 3 | Cycle code 0..7 as listed in the requirements |
| ref_ctr | output | ADDR_W | Internal refresh row counter |
| row_stale | output | 1 | Some row exceeded the refresh window |

## Verification
The bench builds the block with REF_WINDOW set to 64 and the default 8-row by 8-column array. With that window, the stale flag can be made to rise or stay low within about a hundred clocks of a reset. The bench leaves a long gap after reset and then refreshes the rows in a burst, so a refresh sent to the wrong row shows up as a raised flag. With this setup the bench can show that a strobe-first refresh uses the counter row and not the address bus. The small array lets word and byte writes be read back at chosen row and column pairs.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    K_IDLE    = 3'd0,
    K_ROWONLY = 3'd1,
    K_READ    = 3'd2,
    K_EWR     = 3'd3,
    K_LWR     = 3'd4,
    K_RMW     = 3'd5,
    K_CBR     = 3'd6,
    K_HIDDEN  = 3'd7
  } cyc_kind_t;

  // Internal column strobe: active while either byte strobe is low.
  function automatic logic strobe_merge(input logic lo_n, input logic hi_n);
    return (~lo_n) | (~hi_n);
  endfunction

  // Rising edge of a level condition.
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/dcd_cycle_ctl.sv
module dcd_cycle_ctl
  import dcd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_lo_n,
  input  logic              cas_hi_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ctr_row,
  output cyc_kind_t         kind,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_eff,
  output logic [1:0]        drive,
  output logic [1:0]        wr_stb,
  output logic              ref_evt,
  output logic [ADDR_W-1:0] ref_row,
  output logic              ctr_adv
);

  localparam int NBYTE = 2;

  logic ras_now, cas_now, ras_prev, cas_prev;
  logic ras_fall, ras_rise, cas_fall;
  logic norm_start, refresh_start, hidden_start;
  logic row_open, col_valid, early_wr, rd_seen, hold_rd;
  logic col_take, col_live, early_eff;
  logic [ADDR_W-1:0] col_q;
  logic [NBYTE-1:0] strb_now, wcond, wcond_prev;

  assign ras_now  = ~ras_n;
  assign cas_now  = strobe_merge(cas_lo_n, cas_hi_n);
  assign strb_now = {~cas_hi_n, ~cas_lo_n};

  assign ras_fall = rise_of(ras_now, ras_prev);
  assign ras_rise = rise_of(~ras_now, ~ras_prev);
  assign cas_fall = rise_of(cas_now, cas_prev);

  assign norm_start    = ras_fall & ~cas_prev;
  assign refresh_start = ras_fall & cas_prev;
  assign hidden_start  = refresh_start & hold_rd;

  assign col_take  = cas_fall & row_open;
  assign col_live  = row_open & (col_valid | col_take);
  assign col_eff   = col_take ? addr : col_q;
  assign early_eff = col_take ? ~we_n : early_wr;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign drive[b]  = strb_now[b] & ~oe_n & we_n &
                       ((col_live & ~early_eff) | hold_rd);
    assign wcond[b]  = strb_now[b] & ~we_n & col_live;
    assign wr_stb[b] = rise_of(wcond[b], wcond_prev[b]);
  end

  assign ref_evt = norm_start | refresh_start;
  assign ref_row = refresh_start ? ctr_row : addr;
  assign ctr_adv = refresh_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev   <= 1'b0;
      cas_prev   <= 1'b0;
      row_open   <= 1'b0;
      col_valid  <= 1'b0;
      early_wr   <= 1'b0;
      rd_seen    <= 1'b0;
      hold_rd    <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wcond_prev <= '0;
      kind       <= K_IDLE;
    end else begin
      ras_prev   <= ras_now;
      cas_prev   <= cas_now;
      wcond_prev <= wcond;

      if (norm_start) begin
        row_open <= 1'b1;
        row_q    <= addr;
      end else if (ras_rise) begin
        row_open <= 1'b0;
      end

      if (ras_rise)      col_valid <= 1'b0;
      else if (col_take) col_valid <= 1'b1;

      if (ras_rise)      early_wr <= 1'b0;
      else if (col_take) early_wr <= ~we_n;

      if (col_take) col_q <= addr;

      if (ras_rise)      rd_seen <= 1'b0;
      else if (col_take) rd_seen <= |drive;
      else if (|drive)   rd_seen <= 1'b1;

      if (!cas_now)      hold_rd <= 1'b0;
      else if (|drive)   hold_rd <= 1'b1;

      if (refresh_start)
        kind <= hidden_start ? K_HIDDEN : K_CBR;
      else if (norm_start)
        kind <= K_ROWONLY;
      else if (col_take)
        kind <= we_n ? K_READ : K_EWR;
      else if ((|wr_stb) && !early_wr)
        kind <= rd_seen ? K_RMW : K_LWR;
    end
  end

  // R9
  float_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_lo_n && cas_hi_n) |-> (drive == 2'b00));

  // R3
  cbr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_start && !hold_rd) |=> (drive == 2'b00));

  // R8
  hidden_row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_start |=> $stable(row_q));

  // R2
  row_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_start |=> (row_q == $past(addr)));

endmodule

// File: rtl/dcd_refresh_trk.sv
module dcd_refresh_trk #(
  parameter int ADDR_W     = 8,
  parameter int TRK_SEL    = 3,
  parameter int REF_WINDOW = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_evt,
  input  logic [ADDR_W-1:0] ref_row,
  input  logic              ctr_adv,
  output logic [ADDR_W-1:0] ctr,
  output logic              stale
);

  localparam int NTRK  = 1 << TRK_SEL;
  localparam int AGE_W = $clog2(REF_WINDOW + 1);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(REF_WINDOW);

  logic [AGE_W-1:0] age [NTRK];
  logic [NTRK-1:0]  at_lim;
  logic [TRK_SEL-1:0] trk_idx;

  assign trk_idx = ref_row[TRK_SEL-1:0];

  for (genvar g = 0; g < NTRK; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        age[g] <= '0;
      else if (ref_evt && (trk_idx == TRK_SEL'(g)))
        age[g] <= '0;
      else if (age[g] != AGE_LIM)
        age[g] <= age[g] + 1'b1;
    end
    assign at_lim[g] = (age[g] == AGE_LIM);
  end

  assign stale = |at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctr <= '0;
    else if (ctr_adv) ctr <= ctr + 1'b1;
  end

  // R3
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_adv |=> (ctr == $past(ctr) + 1'b1));

  // R3
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_adv |=> $stable(ctr));

endmodule

// File: rtl/dcd_byte_array.sv
module dcd_byte_array #(
  parameter int ROW_SEL = 3,
  parameter int COL_SEL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         wr_stb,
  input  logic [ROW_SEL-1:0] row_idx,
  input  logic [COL_SEL-1:0] col_idx,
  input  logic [15:0]        din,
  output logic [15:0]        rd_data
);

  localparam int IDX_W = ROW_SEL + COL_SEL;
  localparam int NW    = 1 << IDX_W;
  localparam int NBYTE = 2;

  logic [15:0] mem [NW];
  logic [IDX_W-1:0] idx;

  assign idx     = {row_idx, col_idx};
  assign rd_data = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else begin
      for (int b = 0; b < NBYTE; b++)
        if (wr_stb[b]) mem[idx][8*b +: 8] <= din[8*b +: 8];
    end
  end

endmodule

// File: rtl/dualcas_dram_core.sv
module dualcas_dram_core
  import dcd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ROW_SEL    = 3,
  parameter int COL_SEL    = 3,
  parameter int REF_WINDOW = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_lo_n,
  input  logic              cas_hi_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] ref_ctr,
  output logic              row_stale
);

  cyc_kind_t         kind;
  logic [ADDR_W-1:0] row_q, col_eff, ref_row;
  logic [1:0]        drive, wr_stb;
  logic              ref_evt, ctr_adv;
  logic [15:0]       rd_data;

  dcd_cycle_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
    .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .ctr_row(ref_ctr), .kind(kind), .row_q(row_q), .col_eff(col_eff),
    .drive(drive), .wr_stb(wr_stb), .ref_evt(ref_evt), .ref_row(ref_row),
    .ctr_adv(ctr_adv)
  );

  dcd_refresh_trk #(
    .ADDR_W(ADDR_W), .TRK_SEL(ROW_SEL), .REF_WINDOW(REF_WINDOW)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .ref_row(ref_row),
    .ctr_adv(ctr_adv), .ctr(ref_ctr), .stale(row_stale)
  );

  dcd_byte_array #(.ROW_SEL(ROW_SEL), .COL_SEL(COL_SEL)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .row_idx(row_q[ROW_SEL-1:0]), .col_idx(col_eff[COL_SEL-1:0]),
    .din(din), .rd_data(rd_data)
  );

  for (genvar b = 0; b < 2; b++) begin : g_out
    assign dq_out[8*b +: 8] = drive[b] ? rd_data[8*b +: 8] : 8'h00;
  end
  assign dq_oe    = drive;
  assign cyc_kind = kind;

  // R4
  lo_byte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> (!cas_lo_n && !oe_n && we_n));

  // R4
  hi_byte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> (!cas_hi_n && !oe_n && we_n));

  // R5
  write_lo_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[0] |-> (!cas_lo_n && !we_n && !ras_n));

endmodule

// File: tb/sim_dualcas_dram_core.sv
module sim_dualcas_dram_core;

  localparam int AW = 8;
  localparam int WIN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_lo_n = 1'b1, cas_hi_n = 1'b1;
  logic we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [2:0]  cyc_kind;
  logic [AW-1:0] ref_ctr;
  logic row_stale;

  int checks = 0;
  int fails = 0;
  int tcnt = 0;
  logic [AW-1:0] exp_ctr = '0;

  always #4 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1;

  dualcas_dram_core #(.ADDR_W(AW), .REF_WINDOW(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n),
    .cas_hi_n(cas_hi_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dq_out(dq_out), .dq_oe(dq_oe), .cyc_kind(cyc_kind), .ref_ctr(ref_ctr),
    .row_stale(row_stale)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins(input logic r, input logic cl, input logic ch, input logic w,
                      input logic o, input logic [AW-1:0] a, input logic [15:0] d);
    ras_n = r; cas_lo_n = cl; cas_hi_n = ch; we_n = w; oe_n = o; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle();
    pins(1, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ras_n = 1; cas_lo_n = 1; cas_hi_n = 1; we_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tcnt = 0;
    exp_ctr = '0;
    @(negedge clk);
  endtask

  task automatic early_write(input logic [AW-1:0] row, input logic [AW-1:0] col,
                             input logic lo, input logic hi, input logic [15:0] d);
    idle();
    pins(0, 1, 1, 0, 1, row, '0);
    pins(0, ~lo, ~hi, 0, 1, col, d);
    chk("R5 early write code", cyc_kind, 3);
    chk("R5 early write no drive", dq_oe, 0);
    pins(0, ~lo, ~hi, 0, 0, col, d);
    chk("R5 early write stays quiet with oe low", dq_oe, 0);
    idle();
  endtask

  task automatic read_word(input logic [AW-1:0] row, input logic [AW-1:0] col,
                           input logic lo, input logic hi, input logic [1:0] eoe,
                           input logic [15:0] edq, input string tag);
    idle();
    pins(0, 1, 1, 1, 0, row, '0);
    pins(0, ~lo, ~hi, 1, 0, col, '0);
    chk({tag, " read code"}, cyc_kind, 2);
    chk({tag, " read oe"}, dq_oe, eoe);
    chk({tag, " read data"}, dq_out, edq);
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 reset code", cyc_kind, 0);
    chk("R11 reset ctr", ref_ctr, 0);
    chk("R11 reset stale", row_stale, 0);
    chk("R11 reset oe", dq_oe, 0);
    read_word(8'd4, 8'd4, 1, 1, 2'b11, 16'h0000, "R11 zero array");
  endtask

  task automatic t_writes_reads();
    early_write(8'd2, 8'd6, 1, 1, 16'hFFFF);
    early_write(8'd2, 8'd6, 1, 0, 16'h1234);
    early_write(8'd2, 8'd5, 1, 1, 16'hA1B2);
    read_word(8'd2, 8'd5, 1, 1, 2'b11, 16'hA1B2, "R4 word");
    read_word(8'd2, 8'd6, 1, 0, 2'b01, 16'h0034, "R4 lower byte");
    read_word(8'd2, 8'd6, 0, 1, 2'b10, 16'hFF00, "R4 upper byte");
  endtask

  task automatic t_late_write();
    idle();
    pins(0, 1, 1, 1, 1, 8'd3, '0);
    pins(0, 0, 0, 1, 1, 8'd1, '0);
    chk("R6 oe high no drive", dq_oe, 0);
    pins(0, 0, 0, 0, 1, 8'd1, 16'h5A5A);
    chk("R6 late write code", cyc_kind, 4);
    chk("R6 late write no drive", dq_oe, 0);
    idle();
    read_word(8'd3, 8'd1, 1, 1, 2'b11, 16'h5A5A, "R6 readback");
  endtask

  task automatic t_rmw();
    idle();
    pins(0, 1, 1, 1, 0, 8'd3, '0);
    pins(0, 0, 0, 1, 0, 8'd2, '0);
    chk("R7 read phase oe", dq_oe, 2'b11);
    chk("R7 read phase data", dq_out, 16'h0000);
    pins(0, 0, 0, 0, 1, 8'd2, 16'hC3C3);
    chk("R7 rmw code", cyc_kind, 5);
    idle();
    read_word(8'd3, 8'd2, 1, 1, 2'b11, 16'hC3C3, "R7 readback");
  endtask

  task automatic t_merge();
    idle();
    pins(0, 1, 1, 1, 0, 8'd3, '0);
    pins(0, 0, 1, 1, 0, 8'd1, '0);
    chk("R1 first strobe oe", dq_oe, 2'b01);
    pins(0, 0, 0, 1, 0, 8'd2, '0);
    chk("R1 second strobe keeps column", dq_out, 16'h5A5A);
    chk("R1 second strobe oe", dq_oe, 2'b11);
    pins(0, 1, 1, 1, 0, 8'd2, '0);
    chk("R1 strobes high no drive", dq_oe, 0);
    pins(0, 0, 0, 1, 0, 8'd2, '0);
    chk("R1 page new column", dq_out, 16'hC3C3);
    chk("R1 page code", cyc_kind, 2);
    idle();
  endtask

  task automatic t_hidden();
    idle();
    pins(0, 1, 1, 1, 0, 8'd3, '0);
    pins(0, 0, 0, 1, 0, 8'd1, '0);
    chk("R8 read before hidden", dq_out, 16'h5A5A);
    pins(1, 0, 0, 1, 0, 8'd1, '0);
    chk("R1 ras high strobes low keeps drive", dq_oe, 2'b11);
    pins(0, 0, 0, 1, 0, 8'h77, '0);
    exp_ctr = exp_ctr + 1'b1;
    chk("R8 hidden code", cyc_kind, 7);
    chk("R8 hidden ctr", ref_ctr, exp_ctr);
    chk("R8 hidden data held", dq_out, 16'h5A5A);
    chk("R8 hidden oe held", dq_oe, 2'b11);
    idle();
    chk("R9 all high floats", dq_oe, 0);
    read_word(8'd3, 8'd1, 1, 1, 2'b11, 16'h5A5A, "R8 row kept");
  endtask

  task automatic cbr(input logic [AW-1:0] a);
    idle();
    pins(1, 0, 0, 1, 0, '0, '0);
    pins(0, 0, 0, 1, 0, a, '0);
    exp_ctr = exp_ctr + 1'b1;
  endtask

  task automatic t_cbr();
    cbr(8'h33);
    chk("R3 cbr code", cyc_kind, 6);
    chk("R3 cbr ctr", ref_ctr, exp_ctr);
    chk("R3 cbr no drive", dq_oe, 0);
    idle();
    chk("R3 ctr after end", ref_ctr, exp_ctr);
  endtask

  task automatic ras_only(input logic [AW-1:0] row);
    pins(0, 1, 1, 1, 0, row, '0);
    pins(1, 1, 1, 1, 0, row, '0);
  endtask

  task automatic t_rasonly();
    idle();
    pins(0, 1, 1, 1, 0, 8'd5, '0);
    chk("R2 row only code", cyc_kind, 1);
    chk("R2 row only no drive", dq_oe, 0);
    pins(1, 1, 1, 1, 0, 8'd5, '0);
    chk("R2 code kept", cyc_kind, 1);
    chk("R2 ctr untouched", ref_ctr, exp_ctr);
  endtask

  task automatic t_stale();
    do_reset();
    repeat (30) @(negedge clk);
    for (int r = 1; r < 8; r++) ras_only(AW'(r));
    while (tcnt < 72) @(negedge clk);
    chk("R10 unrefreshed row 0 stale", row_stale, 1);
    do_reset();
    repeat (30) @(negedge clk);
    cbr(8'h04);
    idle();
    for (int r = 1; r < 8; r++) ras_only(AW'(r));
    while (tcnt < 72) @(negedge clk);
    chk("R3 cbr refreshed counter row 0", row_stale, 0);
    chk("R10 ctr after cbr", ref_ctr, exp_ctr);
    while (tcnt < 140) @(negedge clk);
    chk("R10 all rows aged out", row_stale, 1);
    for (int r = 0; r < 8; r++) ras_only(AW'(r));
    chk("R10 refresh clears stale", row_stale, 0);
  endtask

  bit done = 1'b0;

  initial begin
    @(negedge clk);
    t_reset();
    t_writes_reads();
    t_late_write();
    t_rmw();
    t_merge();
    t_hidden();
    t_cbr();
    t_rasonly();
    t_stale();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule